// File: doc/BRIEF.md
# Paper Tape Word Assembler

This block packs a stream of 8-bit paper-tape frames into 18-bit words. Frames arrive over a valid/ready handshake. A frame counts only when it carries the marker bit. Leader, trailer and blank frames that lack the marker are consumed and dropped. Each counted frame contributes six data bits. Three counted frames make one word, and the first of the three lands in the top bits. The finished word sits in an output register until a downstream consumer takes it. Input is stalled for as long as that register is full.

A single-cycle end-of-stream strobe marks the end of the input. If the strobe arrives while a word is only partly built, the block drops the partial data and raises a one-cycle error pulse in place of a word. A strobe that lands between words has no effect.

Top module: `tape_word_assembler`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `byte_ready` is 1, `word_valid` is 0 and `short_err` is 0.
- R2: An accepted frame whose bit 7 is 0 adds nothing to the word under construction, and the following counted frames form the word as if that frame had never been sent.
- R3: A counted frame contributes only its bits 5..0; bit 6 of a frame never appears in `word_out`.
- R4: The word is {c0, c1, c2}, where c0 is the first counted frame's data (`word_out[17:12]`), c1 is the second (`word_out[11:6]`) and c2 is the third (`word_out[5:0]`).
- R5: `word_valid` rises in the cycle after the third counted frame is accepted. Until `word_ready` is high at a clock edge, `word_valid` stays 1 and `word_out` holds its value.
- R6: While `word_valid` is 1, `byte_ready` is 0, and frames offered in that time are not consumed.
- R7: When `stream_end` is high at an edge where one or two counted frames are pending (including a counted frame accepted in that same edge that is not the third), `short_err` is 1 for exactly the next cycle, no word is produced, and the partial data is discarded.
- R8: When `stream_end` is high with no counted frame pending, `short_err` stays 0 and no word is produced.
- R9: When `stream_end` arrives in the same edge as the third counted frame, the word is produced normally and `short_err` stays 0.
- R10: After a word is taken, or after a short-word error, the next word is built only from frames accepted after that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in | input | 8 | Tape frame; bit 7 is the marker, bits 5..0 are data |
| byte_valid | input | 1 | A frame is offered on `byte_in` |
| byte_ready | output | 1 | The block can take a frame this cycle |
| stream_end | input | 1 | One-cycle end-of-input strobe |
| word_out | output | 18 | Assembled word |
| word_valid | output | 1 | `word_out` holds a word not yet taken |
| word_ready | input | 1 | The downstream consumer takes the word |
| short_err | output | 1 | One-cycle pulse: input ended inside a word |

## Verification
The hardest case to reach from the ports is an end strobe that lands in the same edge as a counted frame. The outcome depends on whether that frame completes the word. The directed tasks therefore drive `stream_end` together with the second counted frame, which must give an error, and together with the third, which must give a clean word. A second hard case is a stalled output register with new frames still being offered. That case is reached by presenting marked frames with `word_ready` held low, then draining the register and checking that the next word contains only frames sent afterwards.

// File: rtl/tape_asm_pkg.sv
package tape_asm_pkg;
  localparam int FRAME_W_DEF = 8;
  localparam int CHUNK_W_DEF = 6;
  localparam int CHUNKS_DEF  = 3;
  localparam int MARK_BIT_DEF = 7;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_CLEAN = 2'd1,
    END_SHORT = 2'd2
  } end_kind_e;
endpackage

// File: rtl/frame_filter.sv
module frame_filter #(
  parameter int FRAME_W  = tape_asm_pkg::FRAME_W_DEF,
  parameter int CHUNK_W  = tape_asm_pkg::CHUNK_W_DEF,
  parameter int MARK_BIT = tape_asm_pkg::MARK_BIT_DEF
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic               fire,
  output logic               keep,
  output logic [CHUNK_W-1:0] chunk
);
  function automatic logic [CHUNK_W-1:0] data_of(input logic [FRAME_W-1:0] f);
    return f[CHUNK_W-1:0];
  endfunction

  function automatic logic marked(input logic [FRAME_W-1:0] f);
    return f[MARK_BIT];
  endfunction

  assign keep  = fire && marked(frame);
  assign chunk = data_of(frame);
endmodule

// File: rtl/chunk_accum.sv
module chunk_accum
  import tape_asm_pkg::*;
#(
  parameter int CHUNK_W = CHUNK_W_DEF,
  parameter int CHUNKS  = CHUNKS_DEF,
  localparam int WORD_W = CHUNK_W * CHUNKS,
  localparam int CNT_W  = $clog2(CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic              flush,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output end_kind_e         end_kind,
  output logic [CNT_W-1:0]  pending
);
  logic [WORD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_shifted;
  logic              last_chunk;

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] a,
                                                 input logic [CHUNK_W-1:0] c);
    return {a[WORD_W-CHUNK_W-1:0], c};
  endfunction

  assign acc_shifted = shift_in(acc_q, chunk);
  assign last_chunk  = push && (cnt_q == CNT_W'(CHUNKS - 1));
  assign word_done   = last_chunk;
  assign word        = acc_shifted;
  assign pending     = cnt_q;

  always_comb begin
    end_kind = END_NONE;
    if (flush) begin
      if (!last_chunk && (push || cnt_q != '0)) end_kind = END_SHORT;
      else                                      end_kind = END_CLEAN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || last_chunk || flush) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      acc_q <= acc_shifted;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CHUNKS));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/word_hold.sv
module word_hold #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] data_in,
  input  logic              take,
  output logic              valid,
  output logic [WORD_W-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      data_out <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      data_out <= data_in;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take && !load) |=> (valid && $stable(data_out)));
endmodule

// File: rtl/tape_word_assembler.sv
module tape_word_assembler
  import tape_asm_pkg::*;
#(
  parameter int FRAME_W  = FRAME_W_DEF,
  parameter int CHUNK_W  = CHUNK_W_DEF,
  parameter int CHUNKS   = CHUNKS_DEF,
  parameter int MARK_BIT = MARK_BIT_DEF,
  localparam int WORD_W  = CHUNK_W * CHUNKS,
  localparam int CNT_W   = $clog2(CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAME_W-1:0] byte_in,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              stream_end,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              short_err
);
  logic              frame_fire;
  logic              frame_keep;
  logic [CHUNK_W-1:0] frame_chunk;
  logic              word_done;
  logic [WORD_W-1:0] word_built;
  end_kind_e         end_kind;
  logic [CNT_W-1:0]  pending;
  logic              take_word;

  assign byte_ready = !word_valid;
  assign frame_fire = byte_valid && byte_ready;
  assign take_word  = word_valid && word_ready;

  frame_filter #(.FRAME_W(FRAME_W), .CHUNK_W(CHUNK_W), .MARK_BIT(MARK_BIT)) u_filter (
    .frame (byte_in),
    .fire  (frame_fire),
    .keep  (frame_keep),
    .chunk (frame_chunk)
  );

  chunk_accum #(.CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frame_keep),
    .chunk     (frame_chunk),
    .flush     (stream_end),
    .word_done (word_done),
    .word      (word_built),
    .end_kind  (end_kind),
    .pending   (pending)
  );

  word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (word_done),
    .data_in  (word_built),
    .take     (take_word),
    .valid    (word_valid),
    .data_out (word_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) short_err <= 1'b0;
    else        short_err <= (end_kind == END_SHORT);
  end

  assert_unmarked_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && !byte_in[MARK_BIT] && !stream_end) |=> $stable(pending));

  assert_held_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> pending == '0);

  assert_err_no_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> !word_valid);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_err && !stream_end) |=> !short_err);
endmodule

// File: tb/tape_word_assembler_tb.sv
module tape_word_assembler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic        stream_end = 1'b0;
  logic [17:0] word_out;
  logic        word_valid;
  logic        word_ready = 1'b0;
  logic        short_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tape_word_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .stream_end(stream_end), .word_out(word_out),
    .word_valid(word_valid), .word_ready(word_ready), .short_err(short_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0o expected %0o", req, act, exp);
    end
  endtask

  function automatic int expect_word(input int a, input int b, input int c);
    return ((a % 64) * 4096) + ((b % 64) * 64) + (c % 64);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] f, input logic e);
    byte_in = f; byte_valid = 1'b1; stream_end = e;
    tick();
    byte_valid = 1'b0; stream_end = 1'b0;
  endtask

  task automatic end_only();
    stream_end = 1'b1; tick(); stream_end = 1'b0;
  endtask

  task automatic take();
    word_ready = 1'b1; tick(); word_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 byte_ready", byte_ready, 1);
    chk("R1 word_valid", word_valid, 0);
    chk("R1 short_err", short_err, 0);
  endtask

  task automatic t_basic();
    send(8'o205, 0); send(8'o212, 0);
    chk("R5 no early word", word_valid, 0);
    send(8'o277, 0);
    chk("R5 word_valid", word_valid, 1);
    chk("R4 order", word_out, expect_word(8'o05, 8'o12, 8'o77));
    take();
    chk("R5 taken", word_valid, 0);
  endtask

  task automatic t_noise();
    send(8'o000, 0); send(8'o177, 0);
    send(8'hC1, 0);
    send(8'o077, 0);
    send(8'hE3, 0);
    send(8'o100, 0); send(8'o000, 0);
    send(8'h80, 0);
    chk("R2 word after noise", word_valid, 1);
    chk("R3 bit6 dropped", word_out, expect_word(1, 8'h23, 0));
    take();
  endtask

  task automatic t_hold();
    send(8'o201, 0); send(8'o202, 0); send(8'o203, 0);
    chk("R6 ready low", byte_ready, 0);
    byte_in = 8'o277; byte_valid = 1'b1;
    tick(); tick(); tick();
    byte_valid = 1'b0;
    chk("R5 still valid", word_valid, 1);
    chk("R5 held word", word_out, expect_word(1, 2, 3));
    take();
    chk("R6 ready back", byte_ready, 1);
    send(8'o210, 0); send(8'o220, 0); send(8'o230, 0);
    chk("R10 fresh word", word_out, expect_word(8'o10, 8'o20, 8'o30));
    take();
  endtask

  task automatic t_short();
    send(8'o211, 0); send(8'o222, 0);
    end_only();
    chk("R7 err pulse", short_err, 1);
    chk("R7 no word", word_valid, 0);
    tick();
    chk("R7 err one cycle", short_err, 0);
    send(8'o244, 0);
    send(8'o255, 1);
    chk("R7 err with frame", short_err, 1);
    send(8'o201, 0); send(8'o202, 0); send(8'o204, 0);
    chk("R10 after err", word_out, expect_word(1, 2, 4));
    chk("R10 after err valid", word_valid, 1);
    take();
  endtask

  task automatic t_clean_end();
    end_only();
    chk("R8 no err", short_err, 0);
    chk("R8 no word", word_valid, 0);
  endtask

  task automatic t_end_on_last();
    send(8'o276, 0); send(8'o265, 0); send(8'o254, 1);
    chk("R9 word", word_valid, 1);
    chk("R9 value", word_out, expect_word(8'o76, 8'o65, 8'o54));
    chk("R9 no err", short_err, 0);
    take();
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_noise();
    t_hold();
    t_short();
    t_clean_end();
    t_end_on_last();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule